// File: doc/BRIEF.md
# Flash Program/Erase Error Guard

This block sits beside an on-chip flash array. It holds the program and erase enable bits and the erase-block selection, and it works out which flash accesses are allowed at any moment. It drives four permission lines: array read, verify read, program and erase. It also watches four event strobes from the CPU and bus side. If any strobe fires while a program or erase operation is active, the block latches a sticky error flag. It then moves the flash into a protected state: reads stay possible, but any further change to the cells is refused.

A reset or a hardware-standby request clears the flag and every register. A software write cannot clear it. Software standby clears the control and block registers. If an error occurs as standby is entered, the flag is kept. When standby is left, the block lands back in error protection. Software reads the error flag as a read-only bit of the control word. Register reads return data one cycle after the request.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` or `hstby_n` is low, `mode` is 0 (hardware protection). All four permissions are 0, and the error flag and all registers are cleared, asynchronously.
- R2: A write to control address 0 sets program mode from bit 0 (`mode` 2) and erase mode from bit 1 (`mode` 3). A write with both bits set enters neither mode (`mode` 1), and a write of 0 returns to `mode` 1.
- R3: The permissions follow the mode. In mode 1, read and verify are on. In mode 2, verify and program are on. In mode 3, verify and erase are on. In mode 5, only read is on. In modes 0, 4 and 6, all permissions are off.
- R4: A strobe on `ev_flash_rd` during program or erase mode sets `err_flag` at the next edge and clears both enable bits (`mode` 5).
- R5: A strobe on `ev_exc` during program or erase mode sets `err_flag`.
- R6: A strobe on `ev_sleep` during program or erase mode, with `sstby` high in the same cycle, gives `mode` 6. The enable and block registers are cleared and `err_flag` stays 1.
- R7: A strobe on `ev_bus_rel` during program or erase mode sets `err_flag`.
- R8: Event strobes outside program and erase modes leave `err_flag` at 0.
- R9: While `err_flag` is 1, control writes do not change it and do not set the program or erase bits.
- R10: When `sstby` falls in `mode` 6, the block goes to `mode` 5 with `err_flag` still 1.
- R11: A read with `rd_en` returns, one cycle later, either the control word or the block register, selected by `addr`. The control word has bit 0 for program, bit 1 for erase and the top bit for the error flag. The block register at address 1 is zero-extended and keeps only its low NBLK bits on write.
- R12: `sstby` high with no error gives `mode` 4 with all permissions off. The control and block registers are cleared, and writes are ignored while `sstby` is high.
- R13: Pulling `hstby_n` low clears a set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low |
| hstby_n | input | 1 | Hardware standby, active low |
| sstby | input | 1 | Software standby active |
| ev_flash_rd | input | 1 | Read of the flash area (including vector read or fetch) |
| ev_exc | input | 1 | Non-reset exception handling starts |
| ev_sleep | input | 1 | Sleep instruction executed |
| ev_bus_rel | input | 1 | CPU releases bus to DMA controller |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = control word, 1 = block register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after `rd_en` |
| err_flag | output | 1 | Sticky error flag |
| mode | output | 3 | 0 protect, 1 normal, 2 program, 3 erase, 4 standby, 5 error, 6 error standby |
| perm_rd | output | 1 | Array read allowed |
| perm_vf | output | 1 | Verify read allowed |
| perm_pr | output | 1 | Programming allowed |
| perm_er | output | 1 | Erasing allowed |

## Verification
The bench fires each of the four strobes while program or erase mode is active, and fires all of them again from normal mode. A guard that gated wrongly would either miss an error or raise false ones. Once the flag is set, it writes the control word with both zero and an enable bit. A design that let software clear the flag or re-enter programming shows up in the mode and the read-back. It also combines a sleep strobe with standby entry, then releases standby. A design that dropped the flag in standby, or that did not come back to error protection, would return to normal mode. Finally, it checks that hardware standby alone clears the flag, and that writing both enable bits enters neither mode.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int DW   = 8,
  parameter int NBLK = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hstby_n,
  input  logic          sstby,
  input  logic          ev_flash_rd,
  input  logic          ev_exc,
  input  logic          ev_sleep,
  input  logic          ev_bus_rel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err_flag,
  output logic [2:0]    mode,
  output logic          perm_rd,
  output logic          perm_vf,
  output logic          perm_pr,
  output logic          perm_er
);
  localparam logic [2:0] M_PROT = 3'd0, M_NORM = 3'd1, M_PROG = 3'd2, M_ERAS = 3'd3,
                         M_SSTB = 3'd4, M_ERR  = 3'd5, M_ESTB = 3'd6;

  logic            clr_n;
  logic            prog_q, erase_q, err_q;
  logic [NBLK-1:0] blk_q;
  logic [DW-1:0]   ctrl_word, blk_word;

  assign clr_n = rst_n & hstby_n;

  wire pe      = prog_q | erase_q;
  wire hit     = pe & (ev_flash_rd | ev_exc | ev_sleep | ev_bus_rel);
  wire ctrl_wr = wr_en & ~addr & ~sstby & ~err_q & ~hit;
  wire blk_wr  = wr_en & addr & ~sstby;

  always_comb begin
    ctrl_word       = '0;
    ctrl_word[0]    = prog_q;
    ctrl_word[1]    = erase_q;
    ctrl_word[DW-1] = err_q;
    blk_word              = '0;
    blk_word[NBLK-1:0]    = blk_q;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      err_q   <= 1'b0;
      blk_q   <= '0;
      rdata   <= '0;
    end else begin
      if (hit) err_q <= 1'b1;
      if (sstby || hit) begin
        prog_q  <= 1'b0;
        erase_q <= 1'b0;
      end else if (ctrl_wr) begin
        prog_q  <= wdata[0] & ~wdata[1];
        erase_q <= wdata[1] & ~wdata[0];
      end
      if (sstby) blk_q <= '0;
      else if (blk_wr) blk_q <= wdata[NBLK-1:0];
      if (rd_en) rdata <= addr ? blk_word : ctrl_word;
    end
  end

  always_comb begin
    if (!clr_n)       mode = M_PROT;
    else if (sstby)   mode = err_q ? M_ESTB : M_SSTB;
    else if (err_q)   mode = M_ERR;
    else if (prog_q)  mode = M_PROG;
    else if (erase_q) mode = M_ERAS;
    else              mode = M_NORM;
  end

  assign err_flag = err_q;
  assign perm_rd  = (mode == M_NORM) || (mode == M_ERR);
  assign perm_vf  = (mode == M_NORM) || (mode == M_PROG) || (mode == M_ERAS);
  assign perm_pr  = (mode == M_PROG);
  assign perm_er  = (mode == M_ERAS);

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!clr_n) !(prog_q && erase_q));
  a_r4_event_traps: assert property (@(posedge clk) disable iff (!clr_n)
    (pe && (ev_flash_rd || ev_exc || ev_sleep || ev_bus_rel)) |=> (err_q && !prog_q && !erase_q));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!clr_n)
    (!pe && !err_q) |=> !err_q);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!clr_n) err_q |=> err_q);
  a_r12_standby_init: assert property (@(posedge clk) disable iff (!clr_n)
    sstby |=> (!prog_q && !erase_q && blk_q == '0));
  a_r3_err_no_write: assert property (@(posedge clk) disable iff (!clr_n)
    err_flag |-> (!perm_pr && !perm_er && !perm_vf));
  a_r3_one_writer: assert property (@(posedge clk) disable iff (!clr_n) $onehot0({perm_pr, perm_er}));
endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  logic clk = 1'b0, rst_n = 1'b0, hstby_n = 1'b1, sstby = 1'b0;
  logic ev_flash_rd = 1'b0, ev_exc = 1'b0, ev_sleep = 1'b0, ev_bus_rel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic err_flag, perm_rd, perm_vf, perm_pr, perm_er;
  logic [2:0] mode;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_guard #(.DW(8), .NBLK(6)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, int m, int e, logic [3:0] perms);
    chk({req, " mode"}, mode, m);
    chk({req, " err"}, err_flag, e);
    chk({req, " perms"}, {perm_rd, perm_vf, perm_pr, perm_er}, perms);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0; v = rdata;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: ev_flash_rd = 1'b1;
      1: ev_exc = 1'b1;
      2: ev_sleep = 1'b1;
      default: ev_bus_rel = 1'b1;
    endcase
    @(posedge clk); #1 {ev_flash_rd, ev_exc, ev_sleep, ev_bus_rel} = '0;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 1'b0; #1;
    chk_state("R1 reset", 0, 0, 4'b0000);
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic t_modes();
    wr(0, 8'h01); chk_state("R2 program", 2, 0, 4'b0110);
    wr(0, 8'h02); chk_state("R2 erase", 3, 0, 4'b0101);
    wr(0, 8'h03); chk_state("R2 both bits", 1, 0, 4'b1100);
    wr(0, 8'h01); wr(0, 8'h00); chk_state("R2 clear", 1, 0, 4'b1100);
  endtask

  task automatic t_event(int which, string req);
    logic [7:0] v;
    wr(0, (which % 2 == 0) ? 8'h01 : 8'h02);
    pulse(which);
    chk_state(req, 5, 1, 4'b1000);
    rd(0, v); chk({req, " ctrl readback"}, v, 8'h80);
    hard_reset();
    chk_state("R1 after release", 1, 0, 4'b1100);
  endtask

  task automatic t_idle_events();
    for (int i = 0; i < 4; i++) pulse(i);
    chk_state("R8 idle events", 1, 0, 4'b1100);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    wr(0, 8'h02); pulse(3);
    wr(0, 8'h00); wr(0, 8'h01);
    chk_state("R9 sticky", 5, 1, 4'b1000);
    rd(0, v); chk("R9 ctrl readback", v, 8'h80);
    @(negedge clk); hstby_n = 1'b0; #1;
    chk_state("R13 hw standby", 0, 0, 4'b0000);
    @(negedge clk); hstby_n = 1'b1; #1;
    chk_state("R13 release", 1, 0, 4'b1100);
  endtask

  task automatic t_block_reg();
    logic [7:0] v;
    wr(1, 8'h2A); rd(1, v); chk("R11 block read", v, 8'h2A);
    wr(1, 8'hFF); rd(1, v); chk("R11 block width", v, 8'h3F);
    rd(0, v); chk("R11 ctrl read", v, 8'h00);
  endtask

  task automatic t_err_standby();
    logic [7:0] v;
    wr(1, 8'h05); wr(0, 8'h01);
    @(negedge clk); ev_sleep = 1'b1; sstby = 1'b1;
    @(posedge clk); #1 ev_sleep = 1'b0;
    chk_state("R6 error standby", 6, 1, 4'b0000);
    rd(1, v); chk("R6 block cleared", v, 8'h00);
    rd(0, v); chk("R6 ctrl keeps flag", v, 8'h80);
    @(negedge clk); sstby = 1'b0; #1;
    chk_state("R10 standby release", 5, 1, 4'b1000);
    hard_reset();
  endtask

  task automatic t_plain_standby();
    logic [7:0] v;
    wr(1, 8'h03);
    @(negedge clk); sstby = 1'b1;
    @(posedge clk); #1;
    chk_state("R12 standby", 4, 0, 4'b0000);
    wr(0, 8'h01); wr(1, 8'h07);
    chk_state("R12 writes ignored", 4, 0, 4'b0000);
    @(negedge clk); sstby = 1'b0; #1;
    chk_state("R12 release", 1, 0, 4'b1100);
    rd(1, v); chk("R12 block cleared", v, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 chk_state("R1 initial", 0, 0, 4'b0000);
    chk("R1 rdata", rdata, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk_state("R3 normal", 1, 0, 4'b1100);
    t_modes();
    t_event(0, "R4 flash read");
    t_event(1, "R5 exception");
    t_event(3, "R7 bus release");
    t_idle_events();
    t_sticky();
    t_block_reg();
    t_err_standby();
    t_plain_standby();
    finish_run();
  end
endmodule